// File: doc/BRIEF.md
# FIFO Threshold Offset Register Bank

This block holds the four offset registers that place the almost-empty and almost-full thresholds of a deep synchronous FIFO, and turns them into the two programmable flags. The empty threshold is built from a low and a high register, and so is the full threshold. Software loads them through the FIFO's own data input. It holds the load pin low and pulses the write enable. The target register is picked by an internal index that steps through the four registers in a fixed ring. It can read them back on the FIFO's data output path through a second index of the same kind, clocked by the read clock.

The load pin has a second use. Its level while reset is held decides whether the FIFO runs with programmable flags. If it does not, the pin serves as a second write enable for depth expansion, and this block ignores it. The flags compare the occupancy count supplied by the FIFO against the stored thresholds. Almost-empty compares the count itself. Almost-full compares the free space. The FIFO storage and pointers live outside this block.

Top module: `ofs_flag_bank`

## Requirements
- R1: After reset the readback output is zero. Both low registers hold 7, both high registers hold 0, and each index points at the empty-low register.
- R2: The mode is sampled while reset is held: the load pin low selects programmable flags. With the load pin high during reset, later load writes and readbacks have no effect.
- R3: In programmable-flag mode a register is written at a write-clock rising edge only when the load pin and the write enable are both low. Any other edge leaves all four registers unchanged.
- R4: Load writes go in this order: empty-low (index 0), empty-high (1), full-low (2), full-high (3). The write after full-high goes back to empty-low.
- R5: The write index keeps its value while the load pin is high. A new load session therefore continues at the register after the last one written.
- R6: In programmable-flag mode, a read-clock edge with the load pin and both read enables low drives the register at the read index onto the readback output one edge later. The read index then steps through the same ring of four. Otherwise the output holds its value.
- R7: A high register keeps only the low HI_W bits of the input, where HI_W = $clog2(DEPTH)+1-9. It reads back zero-extended to 9 bits.
- R8: almost_empty_n is low exactly when the occupancy is less than or equal to {empty-high, empty-low}.
- R9: almost_full_n is low exactly when DEPTH minus the occupancy is less than or equal to {full-high, full-low}.
- R10: When a load write and a readback are requested at the same edge, the write is performed. The readback output and read index stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen1_n | input | 1 | First write enable, active low |
| ld_n | input | 1 | Load select, active low; mode select during reset |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| din | input | 9 | FIFO data input, source of offset values |
| occupancy | input | $clog2(DEPTH)+1 | Current number of stored words |
| rdata | output | 9 | Offset readback data |
| almost_empty_n | output | 1 | Programmable almost-empty flag, active low |
| almost_full_n | output | 1 | Programmable almost-full flag, active low |

## Verification
The bench builds the block with DEPTH = 1024. That makes the occupancy 11 bits wide and the high registers only 2 bits wide, so truncating a written high value to its register width becomes visible in readback and in the flag thresholds. It also lets the bench set both thresholds across the register boundary at 512. The small depth also puts the full-side boundary, near occupancy 1024, within direct reach of a short occupancy sweep. Both clocks share one source, so the bench can request a load write and a readback at the same edge.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_e;

  localparam int NUM_SLOTS = 4;

  function automatic slot_e next_slot(slot_e s);
    return slot_e'(s + 2'd1);
  endfunction

  function automatic bit slot_is_high(int s);
    return (s == int'(SLOT_E_HI)) || (s == int'(SLOT_F_HI));
  endfunction
endpackage

// File: rtl/ofsb_rst_sync.sv
module ofsb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ofsb_load_bank.sv
module ofsb_load_bank
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int HI_W   = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load_we,
  input  logic [DATA_W-1:0]                din,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] slots
);
  localparam logic [DATA_W-1:0] LO_DEFAULT = DATA_W'(7);
  localparam logic [DATA_W-1:0] HI_MASK    = DATA_W'((1 << HI_W) - 1);

  slot_e widx_q, widx_d;

  always_comb begin
    widx_d = widx_q;
    if (load_we) widx_d = next_slot(widx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) widx_q <= SLOT_E_LO;
    else        widx_q <= widx_d;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam bool_hi = slot_is_high(s);
    localparam logic [DATA_W-1:0] RST_VAL = bool_hi ? '0 : LO_DEFAULT;
    localparam logic [DATA_W-1:0] KEEP    = bool_hi ? HI_MASK : '1;
    logic              hit;
    logic [DATA_W-1:0] val_q, val_d;

    assign hit = load_we && (int'(widx_q) == s);

    always_comb begin
      val_d = val_q;
      if (hit) val_d = din & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= RST_VAL;
      else        val_q <= val_d;
    end

    assign slots[s] = val_q;
  end
endmodule

// File: rtl/ofsb_readback.sv
module ofsb_readback
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_go,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slots,
  output logic [DATA_W-1:0]                rdata
);
  slot_e             ridx_q, ridx_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    ridx_d  = ridx_q;
    rdata_d = rdata_q;
    if (rd_go) begin
      rdata_d = slots[ridx_q];
      ridx_d  = next_slot(ridx_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q  <= SLOT_E_LO;
      rdata_q <= '0;
    end else begin
      ridx_q  <= ridx_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ofsb_flag_cmp.sv
module ofsb_flag_cmp #(
  parameter int DEPTH = 16384,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] occupancy,
  input  logic [CNT_W-1:0] empty_ofs,
  input  logic [CNT_W-1:0] full_ofs,
  output logic             almost_empty_n,
  output logic             almost_full_n
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  logic [CNT_W-1:0] free_space;

  always_comb begin
    free_space     = DEPTH_C - occupancy;
    almost_empty_n = !(occupancy <= empty_ofs);
    almost_full_n  = !(free_space <= full_ofs);
  end
endmodule

// File: rtl/ofs_flag_bank.sv
module ofs_flag_bank
  import ofs_pkg::*;
#(
  parameter int DEPTH  = 16384,
  parameter int DATA_W = 9,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              ld_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  occupancy,
  output logic [DATA_W-1:0] rdata,
  output logic              almost_empty_n,
  output logic              almost_full_n
);
  localparam int HI_W = CNT_W - DATA_W;

  logic wrst_n, rrst_n;
  logic pf_mode_q, pf_mode_d;
  logic load_we, rd_go;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slots;
  logic [CNT_W-1:0] empty_ofs, full_ofs;

  ofsb_rst_sync u_wrst (.clk(wclk), .rst_n(rst_n), .rst_sync_n(wrst_n));
  ofsb_rst_sync u_rrst (.clk(rclk), .rst_n(rst_n), .rst_sync_n(rrst_n));

  // mode is captured while reset is applied and held afterwards
  always_comb begin
    pf_mode_d = pf_mode_q;
    if (!rst_n) pf_mode_d = !ld_n;
  end

  always_ff @(posedge wclk) begin
    pf_mode_q <= pf_mode_d;
  end

  assign load_we = pf_mode_q && !ld_n && !wen1_n;
  // a concurrent load write wins over readback
  assign rd_go   = pf_mode_q && !ld_n && !ren1_n && !ren2_n && wen1_n;

  ofsb_load_bank #(.DATA_W(DATA_W), .HI_W(HI_W)) u_load (
    .clk(wclk), .rst_n(wrst_n), .load_we(load_we), .din(din), .slots(slots)
  );

  ofsb_readback #(.DATA_W(DATA_W)) u_rb (
    .clk(rclk), .rst_n(rrst_n), .rd_go(rd_go), .slots(slots), .rdata(rdata)
  );

  assign empty_ofs = {slots[SLOT_E_HI][HI_W-1:0], slots[SLOT_E_LO]};
  assign full_ofs  = {slots[SLOT_F_HI][HI_W-1:0], slots[SLOT_F_LO]};

  ofsb_flag_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cmp (
    .occupancy(occupancy), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );
endmodule

// File: rtl/ofs_flag_bank_chk.sv
module ofs_flag_bank_chk #(
  parameter int DEPTH  = 16384,
  parameter int DATA_W = 9,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              wen1_n,
  input logic              ld_n,
  input logic              ren1_n,
  input logic              ren2_n,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  occupancy,
  input logic [CNT_W-1:0]  empty_ofs,
  input logic [CNT_W-1:0]  full_ofs,
  input logic              almost_empty_n,
  input logic              almost_full_n
);
  // R6
  rb_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (ld_n || ren1_n || ren2_n) |=> $stable(rdata));

  // R10
  wr_prio_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ld_n && !wen1_n) |=> $stable(rdata));

  // R3
  no_load_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_n || wen1_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R8
  empty_at_zero_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (occupancy == '0) |-> !almost_empty_n);

  // R9
  full_at_depth_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH)) |-> !almost_full_n);
endmodule

bind ofs_flag_bank ofs_flag_bank_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .ld_n(ld_n),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .rdata(rdata), .occupancy(occupancy),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs),
  .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
);

// File: tb/test_ofs_flag_bank.sv
module test_ofs_flag_bank;
  localparam int DEPTH  = 1024;
  localparam int DATA_W = 9;
  localparam int CNT_W  = $clog2(DEPTH) + 1;
  localparam int HI_W   = CNT_W - DATA_W;

  logic clk = 1'b0;
  logic rst_n, wen1_n, ld_n, ren1_n, ren2_n;
  logic [DATA_W-1:0] din;
  logic [CNT_W-1:0]  occupancy;
  logic [DATA_W-1:0] rdata;
  logic ae_n, af_n;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ofs_flag_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_ofs_flag_bank (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen1_n(wen1_n), .ld_n(ld_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .occupancy(occupancy),
    .rdata(rdata), .almost_empty_n(ae_n), .almost_full_n(af_n)
  );

  // occupancy, expected almost_empty_n, expected almost_full_n (default offsets 7/7)
  localparam int NV = 8;
  localparam logic [CNT_W+1:0] VEC [NV] = '{
    {11'd0,    1'b0, 1'b1},
    {11'd6,    1'b0, 1'b1},
    {11'd7,    1'b0, 1'b1},
    {11'd8,    1'b1, 1'b1},
    {11'd500,  1'b1, 1'b1},
    {11'd1016, 1'b1, 1'b1},
    {11'd1017, 1'b1, 1'b0},
    {11'd1024, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wen1_n = 1'b1; ld_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic do_reset(logic ld_level);
    @(negedge clk);
    idle();
    ld_n = ld_level;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic load(logic [DATA_W-1:0] v);
    ld_n = 1'b0; wen1_n = 1'b0; din = v;
    @(negedge clk);
    wen1_n = 1'b1;
  endtask

  task automatic readback(string req, logic [DATA_W-1:0] exp);
    ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge clk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    check(req, rdata, exp);
  endtask

  task automatic flags(string req, int occ, logic e_ae, logic e_af);
    occupancy = CNT_W'(occ);
    #1;
    check({req, " ae"}, ae_n, e_ae);
    check({req, " af"}, af_n, e_af);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(); din = '0; occupancy = '0; rst_n = 1'b0;
    do_reset(1'b0);
    // R1: reset state of readback output
    check("R1 rdata", rdata, 0);
    // R1 R8 R9: default thresholds from the vector table
    for (int i = 0; i < NV; i++) begin
      flags("R8/R9 table", int'(VEC[i][CNT_W+1:2]), VEC[i][1], VEC[i][0]);
    end
    // R1 R6: default readback ring
    readback("R1 e_lo", 9'd7);
    readback("R1 e_hi", 9'd0);
    readback("R6 f_lo", 9'd7);
    readback("R6 f_hi", 9'd0);
    // R6: one read enable high gives no readback
    ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b1;
    @(negedge clk);
    idle();
    check("R6 hold", rdata, 9'd0);
    // R3: load pin low but write enable high stores nothing
    ld_n = 1'b0; din = 9'h0AA;
    repeat (3) @(negedge clk);
    // R3: write enable low with load pin high stores nothing
    ld_n = 1'b1; wen1_n = 1'b0;
    @(negedge clk);
    idle();
    flags("R3 unchanged", 7, 1'b0, 1'b1);
    flags("R3 unchanged", 8, 1'b1, 1'b1);
    // R4 R7: partial session e_lo, e_hi (truncated), f_lo
    load(9'h020);
    load(9'h1FC);
    load(9'h010);
    idle();
    @(negedge clk);
    flags("R8 ofs32", 32, 1'b0, 1'b1);
    flags("R8 ofs32", 33, 1'b1, 1'b1);
    flags("R9 ofs16", 1008, 1'b1, 1'b0);
    flags("R9 ofs16", 1007, 1'b1, 1'b1);
    // R5: new session resumes at f_hi
    load(9'h005);
    idle();
    @(negedge clk);
    flags("R5 fhi", 496, 1'b1, 1'b0);
    flags("R5 fhi", 495, 1'b1, 1'b1);
    // R4: wrap to e_lo
    load(9'h040);
    idle();
    @(negedge clk);
    flags("R4 wrap", 64, 1'b0, 1'b1);
    flags("R4 wrap", 65, 1'b1, 1'b1);
    // R6 R7: readback of programmed values
    readback("R6 e_lo", 9'h040);
    readback("R7 e_hi", 9'h000);
    readback("R6 f_lo", 9'h010);
    readback("R7 f_hi", 9'h001);
    // R10: simultaneous write and read; write goes to e_hi
    ld_n = 1'b0; wen1_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0; din = 9'h0FF;
    @(negedge clk);
    idle();
    check("R10 rdata held", rdata, 9'h001);
    readback("R10 ridx held", 9'h040);
    readback("R10 written R7", 9'h003);
    flags("R10 ofs", 1600 - 1600 + 1024, 1'b0, 1'b0);
    // R2: dual-enable mode ignores loads and readback
    do_reset(1'b1);
    for (int k = 0; k < 4; k++) load(9'h000);
    idle();
    readback("R2 no rb", 9'h000);
    readback("R2 no rb", 9'h000);
    idle();
    flags("R2 defaults", 7, 1'b0, 1'b1);
    flags("R2 defaults", 8, 1'b1, 1'b1);
    flags("R2 defaults", 1017, 1'b1, 1'b0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule